// File: doc/BRIEF.md
# Rate-Dependent Audio Bit Clock Generator

This block derives the serial bit clock and the frame (left/right) clock of an audio port in master mode from a single master clock. How much the master clock is divided depends on two settings: a 3-bit oversampling-rate code, which says how many master-clock cycles make up one sample period, and a flag that selects a multichannel DSP-style frame format. In the DSP format the bit clock runs at the master-clock rate so that eight channels fit into one frame. In the ordinary formats it runs at one half or one quarter of that rate.

Some combinations of format, rate and word length leave too few bit clocks per frame to carry the data. These combinations, and the two unused rate codes, are refused. The block then raises an error flag and holds both clocks low. A new setting is applied only where one frame ends and the next begins, so a change never produces a shortened clock pulse. The only time a setting is applied at once is when the block is idle, which is after reset or while it is halted on an illegal setting.

Top module: `audio_bclk_gen`

## Requirements
- R1: While reset is asserted (synchronous, active low), `bclk`, `frame` and `cfg_err` are all low.
- R2: Rate codes 3'b000 (128 master cycles per sample) and 3'b001 (192 master cycles per sample), with the DSP format off, give a bit clock of master/2. That is 64 or 96 bit-clock rising edges per frame.
- R3: Rate codes 3'b010 (256), 3'b011 (384), 3'b100 (512) and 3'b101 (512), with the DSP format off, give a bit clock of master/4. That is 64, 96, 128 or 128 rising edges per frame.
- R4: With `dsp_fmt`=1 the bit clock is the master clock gated by a run enable. There is one bit-clock rising edge per master cycle, and as many per frame as the rate's master-cycle count.
- R5: In every legal setting the frame period equals the rate's master-cycle count (128, 192, 256, 384 or 512). With the DSP format off, `frame` is high for the first half of the frame.
- R6: With the DSP format on, `frame` is a pulse one master cycle wide at the start of each frame.
- R7: The DSP format with rate code 3'b000 and any word length other than 16 bits is illegal. The word-length encoding is 2'b00=16, 2'b01=20, 2'b10=24, 2'b11=32 bits.
- R8: The DSP format with rate code 3'b001 and 32-bit words (`word_len`=2'b11) is illegal. 24-bit words at that rate are legal.
- R9: Rate codes 3'b110 and 3'b111 are illegal in every format.
- R10: While an illegal setting is active, `cfg_err` is high and `bclk` and `frame` stay low.
- R11: While the block runs, a change on `rate_sel`, `dsp_fmt` or `word_len` takes effect only at the end of the current frame. This includes the frame period, the bit-clock rate and `cfg_err`.
- R12: When idle (the first clock after reset, or halted on an illegal setting), a legal setting starts a frame at the next clock edge, and `frame` is high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel | input | 3 | Oversampling-rate code |
| dsp_fmt | input | 1 | 1 selects the multichannel DSP frame format |
| word_len | input | 2 | Word length: 00=16, 01=20, 10=24, 11=32 bits |
| bclk | output | 1 | Serial bit clock |
| frame | output | 1 | Frame (left/right) clock, or frame pulse in DSP format |
| cfg_err | output | 1 | High while an illegal setting holds the clocks |

## Verification
The checker watches several things on every master cycle. The divide-by-2 bit clock alternates each cycle, a divide-by-4 high phase lasts two cycles, and the DSP frame pulse is one cycle wide. The gated bit-clock enable is open only while a running DSP setting is active. An illegal setting leaves both clocks low. The applied setting holds still everywhere except at a frame's last cycle, and each refused combination raises the flag once the block is idle. The bench's scenarios cover what needs whole frames: edge counts and frame periods for every rate code, the deferral of a change made mid-frame, the restart from a halted state, and the reset values.

// File: rtl/bclk_pkg.sv
`timescale 1ns/1ps
// bclk_pkg: shared encodings for the bit clock generator.
// Assumes the rate and word-length codes are fixed by the register layout
// of the surrounding audio port.
package bclk_pkg;

    localparam int unsigned RATE_W   = 3;
    localparam int unsigned WL_W     = 2;
    localparam int unsigned DIVLOG_W = 2;

    // Oversampling rate codes; the two top codes are reserved.
    typedef enum logic [RATE_W-1:0] {
        FS_128  = 3'd0,
        FS_192  = 3'd1,
        FS_256  = 3'd2,
        FS_384  = 3'd3,
        FS_512A = 3'd4,
        FS_512B = 3'd5,
        FS_RSV6 = 3'd6,
        FS_RSV7 = 3'd7
    } rate_e;

    // Word length codes.
    typedef enum logic [WL_W-1:0] {
        WL_16 = 2'd0,
        WL_20 = 2'd1,
        WL_24 = 2'd2,
        WL_32 = 2'd3
    } wlen_e;

endpackage

// File: rtl/bclk_cfg_decode.sv
`timescale 1ns/1ps
// bclk_cfg_decode: turns the raw rate code, format flag and word length
// into a legality bit, a log2 divide ratio and the bit count per frame.
// Purely combinational. Assumes CNT_W can hold the largest frame (512).
module bclk_cfg_decode
    import bclk_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic [RATE_W-1:0]   rate_i,
    input  logic                dsp_i,
    input  logic [WL_W-1:0]     wl_i,
    output logic                legal_o,
    output logic [DIVLOG_W-1:0] div_log_o,
    output logic [CNT_W-1:0]    nbits_o
);

    rate_e            rate;
    wlen_e            wlen;
    logic [CNT_W-1:0] fs_mult;
    logic             rsv_code;
    logic             dsp_short128;
    logic             dsp_short192;

    assign rate = rate_e'(rate_i);
    assign wlen = wlen_e'(wl_i);

    // Master-clock cycles per sample period for each rate code.
    always_comb begin
        case (rate)
            FS_128:           fs_mult = CNT_W'(128);
            FS_192:           fs_mult = CNT_W'(192);
            FS_256:           fs_mult = CNT_W'(256);
            FS_384:           fs_mult = CNT_W'(384);
            FS_512A, FS_512B: fs_mult = CNT_W'(512);
            default:          fs_mult = CNT_W'(128);
        endcase
    end

    // Divide ratio: DSP runs at master rate, low rates halve, high rates quarter.
    always_comb begin
        if (dsp_i)
            div_log_o = DIVLOG_W'(0);
        else if (rate == FS_128 || rate == FS_192)
            div_log_o = DIVLOG_W'(1);
        else
            div_log_o = DIVLOG_W'(2);
    end

    // Bit clock periods per frame.
    assign nbits_o = fs_mult >> div_log_o;

    // Combinations that cannot carry eight channels, plus reserved codes.
    assign rsv_code     = (rate == FS_RSV6) || (rate == FS_RSV7);
    assign dsp_short128 = dsp_i && (rate == FS_128) && (wlen != WL_16);
    assign dsp_short192 = dsp_i && (rate == FS_192) && (wlen == WL_32);
    assign legal_o      = !(rsv_code || dsp_short128 || dsp_short192);

endmodule

// File: rtl/bclk_phase_gen.sv
`timescale 1ns/1ps
// bclk_phase_gen: master-cycle phase counter inside one bit period, the
// registered bit clock for divide-by-2/4 and the gate enable for divide-by-1.
// Assumes the caller supplies both the active and the next configuration,
// and asserts reload_i at every frame boundary and while idle.
module bclk_phase_gen
    import bclk_pkg::*;
#(
    parameter int unsigned PH_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                dsp_i,
    input  logic [DIVLOG_W-1:0] div_log_i,
    input  logic                reload_i,
    input  logic                nxt_run_i,
    input  logic                nxt_dsp_i,
    input  logic [DIVLOG_W-1:0] nxt_div_log_i,
    output logic                period_end_o,
    output logic                bclk_reg_o,
    output logic                bclk_gate_o
);

    localparam logic [PH_W:0] PH_ONE = (PH_W+1)'(1);

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] ph_d;
    logic [PH_W:0]   div_cur;
    logic [PH_W:0]   div_nxt;
    logic            bclk_reg_d;

    assign div_cur = PH_ONE << div_log_i;
    assign div_nxt = PH_ONE << nxt_div_log_i;

    // Last master cycle of the current bit period.
    assign period_end_o = run_i && ({1'b0, ph_q} == (div_cur - PH_ONE));

    // Next phase: restart at a reload or at the end of a bit period.
    always_comb begin
        if (reload_i || period_end_o)
            ph_d = '0;
        else
            ph_d = ph_q + PH_W'(1);
    end

    // Divided bit clock is low in the first half of the period, high in the second.
    assign bclk_reg_d = nxt_run_i && !nxt_dsp_i && ({1'b0, ph_d} >= (div_nxt >> 1));

    // Phase counter and registered divided clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q       <= '0;
            bclk_reg_o <= 1'b0;
        end else begin
            ph_q       <= ph_d;
            bclk_reg_o <= bclk_reg_d;
        end
    end

    // Gate enable changes only while the master clock is low, so no runt pulse.
    always_ff @(negedge clk) begin
        if (!rst_n)
            bclk_gate_o <= 1'b0;
        else
            bclk_gate_o <= run_i && dsp_i;
    end

endmodule

// File: rtl/bclk_frame_ctr.sv
`timescale 1ns/1ps
// bclk_frame_ctr: counts bit periods inside a frame and forms the frame
// clock: a half-frame level in ordinary formats, a one-bit pulse in DSP format.
// Assumes period_end_i marks the last master cycle of each bit period.
module bclk_frame_ctr #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_end_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] nbits_i,
    input  logic             nxt_run_i,
    input  logic             nxt_dsp_i,
    input  logic [CNT_W-1:0] nxt_nbits_i,
    output logic             last_bit_o,
    output logic             frame_o
);

    logic [CNT_W-1:0] bit_q;
    logic [CNT_W-1:0] bit_d;
    logic             frame_d;

    // Current bit is the final one of the frame.
    assign last_bit_o = (bit_q == (nbits_i - CNT_W'(1)));

    // Next bit index: restart on reload, advance at each bit-period end.
    always_comb begin
        if (reload_i)
            bit_d = '0;
        else if (period_end_i)
            bit_d = bit_q + CNT_W'(1);
        else
            bit_d = bit_q;
    end

    // Frame level for the coming cycle, from the coming bit index.
    always_comb begin
        if (!nxt_run_i)
            frame_d = 1'b0;
        else if (nxt_dsp_i)
            frame_d = (bit_d == '0);
        else
            frame_d = (bit_d < (nxt_nbits_i >> 1));
    end

    // Bit counter and registered frame clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q   <= '0;
            frame_o <= 1'b0;
        end else begin
            bit_q   <= bit_d;
            frame_o <= frame_d;
        end
    end

endmodule

// File: rtl/audio_bclk_gen.sv
`timescale 1ns/1ps
// audio_bclk_gen: master-mode bit clock and frame clock generator.
// Holds an active configuration that is replaced only at a frame boundary
// or while idle; illegal settings halt both clocks and raise cfg_err.
// Assumes all inputs are synchronous to mclk.
module audio_bclk_gen
    import bclk_pkg::*;
#(
    parameter int unsigned FS_MAX  = 512,
    parameter int unsigned DIV_MAX = 4
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              dsp_fmt,
    input  logic [WL_W-1:0]   word_len,
    output logic              bclk,
    output logic              frame,
    output logic              cfg_err
);

    localparam int unsigned CNT_W = $clog2(FS_MAX) + 1;
    localparam int unsigned PH_W  = $clog2(DIV_MAX);

    logic                in_legal;
    logic [DIVLOG_W-1:0] in_div_log;
    logic [CNT_W-1:0]    in_nbits;

    logic                run_q;
    logic                err_q;
    logic                act_dsp_q;
    logic [RATE_W-1:0]   act_rate_q;
    logic [DIVLOG_W-1:0] act_div_log_q;
    logic [CNT_W-1:0]    act_nbits_q;

    logic                boundary;
    logic                nxt_run;
    logic                nxt_dsp;
    logic [DIVLOG_W-1:0] nxt_div_log;
    logic [CNT_W-1:0]    nxt_nbits;

    logic                period_end;
    logic                last_bit;
    logic                bclk_reg;
    logic                bclk_gate;

    bclk_cfg_decode #(.CNT_W(CNT_W)) u_decode (
        .rate_i    (rate_sel),
        .dsp_i     (dsp_fmt),
        .wl_i      (word_len),
        .legal_o   (in_legal),
        .div_log_o (in_div_log),
        .nbits_o   (in_nbits)
    );

    // A new setting may be taken when idle or on the frame's last master cycle.
    assign boundary = !run_q || (period_end && last_bit);

    // Configuration seen by the counters after the coming edge.
    assign nxt_run     = boundary ? in_legal   : run_q;
    assign nxt_dsp     = boundary ? dsp_fmt    : act_dsp_q;
    assign nxt_div_log = boundary ? in_div_log : act_div_log_q;
    assign nxt_nbits   = boundary ? in_nbits   : act_nbits_q;

    // Active configuration register, swapped only at a boundary.
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            run_q         <= 1'b0;
            err_q         <= 1'b0;
            act_dsp_q     <= 1'b0;
            act_rate_q    <= '0;
            act_div_log_q <= '0;
            act_nbits_q   <= '0;
        end else if (boundary) begin
            run_q         <= in_legal;
            err_q         <= !in_legal;
            act_dsp_q     <= dsp_fmt;
            act_rate_q    <= rate_sel;
            act_div_log_q <= in_div_log;
            act_nbits_q   <= in_nbits;
        end
    end

    bclk_phase_gen #(.PH_W(PH_W)) u_phase (
        .clk           (mclk),
        .rst_n         (rst_n),
        .run_i         (run_q),
        .dsp_i         (act_dsp_q),
        .div_log_i     (act_div_log_q),
        .reload_i      (boundary),
        .nxt_run_i     (nxt_run),
        .nxt_dsp_i     (nxt_dsp),
        .nxt_div_log_i (nxt_div_log),
        .period_end_o  (period_end),
        .bclk_reg_o    (bclk_reg),
        .bclk_gate_o   (bclk_gate)
    );

    bclk_frame_ctr #(.CNT_W(CNT_W)) u_frame (
        .clk          (mclk),
        .rst_n        (rst_n),
        .period_end_i (period_end),
        .reload_i     (boundary),
        .nbits_i      (act_nbits_q),
        .nxt_run_i    (nxt_run),
        .nxt_dsp_i    (nxt_dsp),
        .nxt_nbits_i  (nxt_nbits),
        .last_bit_o   (last_bit),
        .frame_o      (frame)
    );

    // Divide-by-1 path is the gated master clock; the other paths are registered.
    assign bclk    = (mclk & bclk_gate) | bclk_reg;
    assign cfg_err = err_q;

endmodule

// File: rtl/bclk_gen_checker.sv
`timescale 1ns/1ps
// bclk_gen_checker: cycle properties of audio_bclk_gen, attached by bind.
module bclk_gen_checker (
    input logic       mclk,
    input logic       rst_n,
    input logic [2:0] rate_sel,
    input logic       dsp_fmt,
    input logic [1:0] word_len,
    input logic       frame,
    input logic       cfg_err,
    input logic       run,
    input logic       act_dsp,
    input logic [1:0] act_div_log,
    input logic [2:0] act_rate,
    input logic       bclk_reg,
    input logic       bclk_gate,
    input logic       period_end,
    input logic       last_bit
);

    // R2: divide-by-2 clock alternates on every master cycle.
    p_div2_alt_r2: assert property (@(posedge mclk) disable iff (!rst_n)
        (run && !act_dsp && act_div_log == 2'd1) |=> (bclk_reg != $past(bclk_reg)));

    // R3: divide-by-4 high phase lasts two master cycles.
    p_div4_high_r3: assert property (@(posedge mclk) disable iff (!rst_n)
        (run && act_div_log == 2'd2 && $rose(bclk_reg)) |=> bclk_reg);

    // R4: gated path is open only for a running DSP setting.
    p_gate_dsp_r4: assert property (@(posedge mclk) disable iff (!rst_n)
        bclk_gate |-> (run && act_dsp));

    // R6: DSP frame pulse is one cycle wide.
    p_dsp_pulse_r6: assert property (@(posedge mclk) disable iff (!rst_n)
        (act_dsp && frame) |=> !frame);

    // R7: DSP at the lowest rate with long words is refused.
    p_dsp128_r7: assert property (@(posedge mclk) disable iff (!rst_n)
        (!run && dsp_fmt && rate_sel == 3'd0 && word_len != 2'd0) |=> cfg_err);

    // R8: DSP at the 192 rate with 32-bit words is refused.
    p_dsp192_r8: assert property (@(posedge mclk) disable iff (!rst_n)
        (!run && dsp_fmt && rate_sel == 3'd1 && word_len == 2'd3) |=> cfg_err);

    // R9: reserved rate codes are refused.
    p_rsv_code_r9: assert property (@(posedge mclk) disable iff (!rst_n)
        (!run && rate_sel[2:1] == 2'b11) |=> cfg_err);

    // R10: clocks stay low while the error flag is set.
    p_quiet_err_r10: assert property (@(posedge mclk) disable iff (!rst_n)
        cfg_err |-> (!frame && !bclk_reg && !bclk_gate));

    // R11: the applied setting and flag move only at a frame's last cycle.
    p_hold_cfg_r11: assert property (@(posedge mclk) disable iff (!rst_n)
        (run && !(period_end && last_bit)) |=>
            ($stable(act_rate) && $stable(act_dsp) && $stable(cfg_err)));

endmodule

bind audio_bclk_gen bclk_gen_checker i_chk (
    .mclk        (mclk),
    .rst_n       (rst_n),
    .rate_sel    (rate_sel),
    .dsp_fmt     (dsp_fmt),
    .word_len    (word_len),
    .frame       (frame),
    .cfg_err     (cfg_err),
    .run         (run_q),
    .act_dsp     (act_dsp_q),
    .act_div_log (act_div_log_q),
    .act_rate    (act_rate_q),
    .bclk_reg    (bclk_reg),
    .bclk_gate   (bclk_gate),
    .period_end  (period_end),
    .last_bit    (last_bit)
);

// File: tb/test_audio_bclk_gen.sv
`timescale 1ns/1ps
module test_audio_bclk_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rate_sel = 3'd0;
    logic       dsp_fmt = 1'b0;
    logic [1:0] word_len = 2'd0;
    logic       bclk;
    logic       frame;
    logic       cfg_err;

    int n_checks = 0;
    int n_fails  = 0;
    int edges    = 0;
    int cyc      = 0;

    audio_bclk_gen i_audio_bclk_gen (
        .mclk     (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .dsp_fmt  (dsp_fmt),
        .word_len (word_len),
        .bclk     (bclk),
        .frame    (frame),
        .cfg_err  (cfg_err)
    );

    always #2.5 clk = ~clk;

    always @(posedge bclk) edges++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_run = 0, m_err = 0, m_dsp = 0, m_div = 2, m_nb = 64;
    int m_ph = 0, m_bit = 0, m_gate = 0;

    function automatic int fs_of(input int r);
        case (r)
            0: return 128;
            1: return 192;
            2: return 256;
            3: return 384;
            4, 5: return 512;
            default: return 128;
        endcase
    endfunction

    function automatic bit legal_of(input int r, input int d, input int w);
        if (r >= 6) return 1'b0;
        if (d != 0 && r == 0 && w != 0) return 1'b0;
        if (d != 0 && r == 1 && w == 3) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_run = 0; m_err = 0; m_dsp = 0; m_ph = 0; m_bit = 0;
        end else if (m_run == 0 || (m_ph == m_div - 1 && m_bit == m_nb - 1)) begin
            m_run = legal_of(rate_sel, dsp_fmt, word_len) ? 1 : 0;
            m_err = 1 - m_run;
            m_dsp = dsp_fmt;
            m_div = dsp_fmt ? 1 : (rate_sel < 2 ? 2 : 4);
            m_nb  = fs_of(rate_sel) / m_div;
            m_ph  = 0;
            m_bit = 0;
        end else if (m_ph == m_div - 1) begin
            m_ph  = 0;
            m_bit = m_bit + 1;
        end else begin
            m_ph = m_ph + 1;
        end
    end

    always @(negedge clk) m_gate = (rst_n && m_run != 0 && m_dsp != 0) ? 1 : 0;

    function automatic int exp_vec(input bit high_phase);
        int bq, fr;
        bq = (m_run != 0 && m_dsp == 0 && m_ph >= m_div / 2) ? 1 : 0;
        fr = (m_run != 0 && (m_dsp != 0 ? m_bit == 0 : m_bit < m_nb / 2)) ? 1 : 0;
        if (high_phase && m_gate != 0) bq = 1;
        return bq * 4 + fr * 2 + m_err;
    endfunction

    function automatic string tag_now();
        if (m_err != 0) return "R10";
        if (m_run == 0) return "R12";
        if (m_dsp != 0) return "R4";
        if (m_div == 2) return "R2";
        return "R3";
    endfunction

    // compare in the high phase, then in the low phase of each master cycle
    always @(posedge clk) begin
        #1;
        if (cyc >= 2)
            chk({bclk, frame, cfg_err} == 3'(exp_vec(1'b1)), tag_now(),
                "model {bclk,frame,err} high phase", int'({bclk, frame, cfg_err}), exp_vec(1'b1));
    end

    always @(negedge clk) begin
        #1;
        if (cyc >= 2)
            chk({bclk, frame, cfg_err} == 3'(exp_vec(1'b0)), tag_now(),
                "model {bclk,frame,err} low phase", int'({bclk, frame, cfg_err}), exp_vec(1'b0));
    end

    // ---------------- scenario helpers ----------------
    task automatic apply(input int r, input int d, input int w);
        @(posedge clk);
        #1.8;
        rate_sel = 3'(r);
        dsp_fmt  = d[0];
        word_len = 2'(w);
    endtask

    task automatic measure(output int mc, output int bc, output int hc);
        int  b0;
        bit  prev;
        @(posedge frame);
        #1;
        b0 = edges; mc = 0; hc = 1; prev = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            mc++;
            if (frame && !prev) break;
            if (frame) hc++;
            prev = frame;
        end
        bc = edges - b0;
    endtask

    task automatic run_cfg(input int r, input int d, input int w, input int fs,
                           input int bits, input int hi, input string req, input string frq);
        int mc, bc, hc;
        apply(r, d, w);
        measure(mc, bc, hc);
        measure(mc, bc, hc);
        chk(mc == fs, frq, "frame period in master cycles", mc, fs);
        chk(bc == bits, req, "bit clock edges per frame", bc, bits);
        chk(hc == hi, frq, "frame high cycles", hc, hi);
        chk(cfg_err == 1'b0, req, "error flag on legal setting", cfg_err, 0);
    endtask

    task automatic expect_err(input int r, input int d, input int w, input string req);
        int e0, fhi;
        apply(r, d, w);
        repeat (600) @(posedge clk);
        #1;
        chk(cfg_err == 1'b1, req, "error flag on illegal setting", cfg_err, 1);
        e0 = edges; fhi = 0;
        repeat (64) begin
            @(posedge clk);
            #1;
            if (frame) fhi++;
        end
        chk(edges == e0, "R10", "bit clock edges while halted", edges - e0, 0);
        chk(fhi == 0, "R10", "frame high cycles while halted", fhi, 0);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int  mc;
        bit  prev;
        int  bc, hc;

        repeat (4) @(posedge clk);
        #1;
        chk(bclk == 1'b0 && frame == 1'b0 && cfg_err == 1'b0, "R1", "outputs in reset",
            int'({bclk, frame, cfg_err}), 0);
        @(posedge clk);
        #1.8;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(frame == 1'b1, "R12", "frame right after reset release", frame, 1);

        run_cfg(0, 0, 0, 128, 64, 64, "R2", "R5");
        run_cfg(1, 0, 3, 192, 96, 96, "R2", "R5");
        run_cfg(2, 0, 0, 256, 64, 128, "R3", "R5");
        run_cfg(3, 0, 1, 384, 96, 192, "R3", "R5");
        run_cfg(4, 0, 2, 512, 128, 256, "R3", "R5");
        run_cfg(5, 0, 3, 512, 128, 256, "R3", "R5");
        run_cfg(0, 1, 0, 128, 128, 1, "R4", "R6");
        run_cfg(1, 1, 2, 192, 192, 1, "R8", "R6");
        run_cfg(4, 1, 3, 512, 512, 1, "R4", "R6");

        expect_err(0, 1, 1, "R7");
        expect_err(0, 1, 3, "R7");
        expect_err(1, 1, 3, "R8");
        expect_err(6, 0, 0, "R9");
        expect_err(7, 1, 2, "R9");

        // restart from a halted state
        apply(2, 0, 0);
        @(posedge clk);
        #1;
        chk(frame == 1'b1 && cfg_err == 1'b0, "R12", "frame after leaving halt",
            int'({frame, cfg_err}), 2);

        // mid-frame rate change waits for the frame end
        measure(mc, bc, hc);
        @(posedge frame);
        #1.8;
        rate_sel = 3'd4;
        mc = 0; prev = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            mc++;
            if (frame && !prev) break;
            prev = frame;
        end
        chk(mc == 256, "R11", "frame after mid-frame change keeps old period", mc, 256);
        measure(mc, bc, hc);
        chk(mc == 512, "R11", "following frame uses new period", mc, 512);

        // mid-frame illegal setting: flag waits for the frame end
        @(posedge frame);
        #1.8;
        rate_sel = 3'd6;
        repeat (20) @(posedge clk);
        #1;
        chk(cfg_err == 1'b0, "R11", "flag deferred inside frame", cfg_err, 0);
        repeat (600) @(posedge clk);
        #1;
        chk(cfg_err == 1'b1, "R9", "flag set after frame end", cfg_err, 1);

        apply(0, 0, 0);
        repeat (10) @(posedge clk);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R11 watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule